// File: doc/BRIEF.md
# Serial Acquisition Link Message Engine

This block is the controller end of a point-to-point acquisition link made of one dedicated clock line and one bidirectional data line. On a request it serializes a command frame down the link. The frame is a start bit, an 8-bit command code with one even-parity bit, and a 16-bit event number. No preamble is needed because the clock line runs all the time. The first clock rising edge that meets the start-bit level is the common-stop instant, and the block reports it on a one-cycle strobe.

After the last event bit the engine releases the data line. It waits a programmable number of link bit periods (the dead time), during which the line is ignored, and then hunts for the reply start bit. The reply carries, in order:
- an echo of the command code with its parity bit;
- the event number, a board identifier and a status word;
- the requested number of 16-bit data words (0 to 62);
- a CRC-16.

The engine checks the parity and the CRC and pulses a done strobe. Data words are held back in an internal buffer. They are released on a valid/ready port only when both checks pass, and are discarded otherwise. A new request is accepted only when the engine is idle and every released word has been read.

Top module: `daq_link_engine`

## Requirements
- R1: While no frame is sent, `line_oe` and `line_out` are 0. A command frame is 26 consecutive bit periods. The bits are: a 1 start bit, `req_cmd` bit 7 down to bit 0, one even-parity bit (the XOR of the eight command bits), then `req_event` bit 15 down to bit 0. `line_out` only changes when `lclk_out` falls.
- R2: `lclk_out` runs continuously with a period of DIV clock cycles. It is low for the first DIV/2 cycles of each bit period and high for the rest.
- R3: `cstop` is high for exactly one clock cycle per command frame. That cycle is the first cycle in which `lclk_out` is high while the start bit is driven.
- R4: `line_oe` drops at the end of the last event bit. Reply bits arriving during the next `dead_bits` bit periods are ignored, including a 1 level.
- R5: After the dead time the engine samples `line_in` at each `lclk_out` rising edge until it sees a 1 (the reply start bit). Idle 0 periods before the start bit are allowed. The start bit is followed by 9 echo bits, then 16-bit words MSB first: event, board, status, N data words, CRC.
- R6: `parity_error` is set when the nine echo bits contain an odd number of ones.
- R7: The CRC is CRC-16 with polynomial 0x1021 and initial value 0xFFFF. It is computed MSB first over the event, board, status and data words. `crc_error` is set when the received CRC word differs from it.
- R8: `done` pulses for one cycle after the last CRC bit is sampled. From that cycle on, `rsp_event`, `rsp_board`, `rsp_status`, `parity_error` and `crc_error` hold the frame's values until the next request is accepted.
- R9: When both checks pass, the N data words appear on `word_data` in arrival order under `word_valid`/`word_ready`. They stay stable while stalled. When either check fails, no word is presented.
- R10: A `req_nwords` value above 62 is treated as 62. A value of 0 gives a reply with no data words.
- R11: After reset `req_ready` is 1 and `done`, the error flags and `word_valid` are 0. `req_ready` is 0 from acceptance until the reply has ended and all released words have been read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request to send a command frame |
| req_ready | output | 1 | Engine can accept a request |
| req_cmd | input | 8 | Command code |
| req_event | input | 16 | Event number |
| req_nwords | input | 6 | Data words expected in the reply |
| dead_bits | input | 8 | Dead time in bit periods |
| lclk_out | output | 1 | Link clock line |
| line_out | output | 1 | Data line value when driven |
| line_oe | output | 1 | Data line drive enable |
| line_in | input | 1 | Data line value as received |
| cstop | output | 1 | Common-stop strobe |
| done | output | 1 | Reply frame finished |
| parity_error | output | 1 | Echo parity failed |
| crc_error | output | 1 | Reply CRC failed |
| rsp_event | output | 16 | Event number of the reply |
| rsp_board | output | 16 | Board identifier of the reply |
| rsp_status | output | 16 | Status word of the reply |
| word_valid | output | 1 | Data word available |
| word_ready | input | 1 | Data word accepted |
| word_data | output | 16 | Data word |

## Verification
The bench targets several boundaries:
- The dead-time boundary is driven with a 1 level held through the whole dead window. An engine that counted one period short would take that level as a start bit and mis-frame every field.
- Reply lengths of 0, 61 and 62 words and the clamped request of 63 are sent. A wrong word count would read a data word as the CRC and flag a CRC error.
- Corrupted parity, corrupted CRC, and both together are sent. An engine that forwarded words before the check would present words from a failed frame.
- The command code is swept over every value class. A stall during readout exposes data that moves while `word_ready` is low.

// File: rtl/dl_pkg.sv
// Shared definitions for the serial link message engine.
package dl_pkg;

    localparam int WORD_W = 16;
    localparam logic [15:0] CRC_INIT = 16'hFFFF;
    localparam logic [15:0] CRC_POLY = 16'h1021;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_ARM,
        RX_DEAD,
        RX_HUNT,
        RX_RECV
    } rx_state_t;

    // Advance the CRC register by one bit, most significant bit first.
    function automatic logic [15:0] crc16_bit(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[15] ^ b;
        return {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    endfunction

endpackage

// File: rtl/dl_bit_timer.sv
// Bit timing for the link. Divides the system clock into bit periods of
// DIV cycles and drives the link clock low in the first half, high in the
// second. Assumes DIV is even and at least 2.
module dl_bit_timer #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic lclk,
    output logic bit_end,
    output logic bit_mid
);
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int HALF = DIV / 2;

    logic [CW-1:0] cnt;

    // Free-running position counter inside the bit period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt == CW'(DIV - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign lclk    = (cnt >= CW'(HALF));
    assign bit_end = (cnt == CW'(DIV - 1));
    assign bit_mid = (cnt == CW'(HALF));
endmodule

// File: rtl/dl_cmd_tx.sv
// Command frame serializer. Loads start bit, command, even parity and event
// number on a request and shifts them out one bit per period, starting at the
// next period boundary. Assumes load only arrives while idle.
module dl_cmd_tx
    import dl_pkg::*;
#(
    parameter int CMD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CMD_W-1:0]  cmd,
    input  logic [WORD_W-1:0] evnum,
    input  logic              bit_end,
    input  logic              bit_mid,
    output logic              line_out,
    output logic              line_oe,
    output logic              cstop,
    output logic              tx_end,
    output logic              busy
);
    localparam int FRAME = 2 + CMD_W + WORD_W;
    localparam int IW    = $clog2(FRAME);

    logic             pend;
    logic             oe;
    logic [FRAME-1:0] shreg;
    logic [IW-1:0]    idx;

    // Frame sequencing: wait for a boundary, drive FRAME bits, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend   <= 1'b0;
            oe     <= 1'b0;
            shreg  <= '0;
            idx    <= '0;
            tx_end <= 1'b0;
        end else begin
            tx_end <= 1'b0;
            if (load) begin
                pend  <= 1'b1;
                shreg <= {1'b1, cmd, ^cmd, evnum};
            end else if (bit_end) begin
                if (pend) begin
                    pend <= 1'b0;
                    oe   <= 1'b1;
                    idx  <= '0;
                end else if (oe) begin
                    if (idx == IW'(FRAME - 1)) begin
                        oe     <= 1'b0;
                        tx_end <= 1'b1;
                    end else begin
                        idx   <= idx + 1'b1;
                        shreg <= shreg << 1;
                    end
                end
            end
        end
    end

    assign line_oe  = oe;
    assign line_out = oe & shreg[FRAME-1];
    assign cstop    = oe && (idx == '0) && bit_mid;
    assign busy     = pend | oe;
endmodule

// File: rtl/dl_rsp_rx.sv
// Reply deserializer. Counts the dead time after the line is released, hunts
// the start bit, collects echo, header and data words, checks echo parity and
// CRC, and hands data words to the buffer with a commit at the end.
// Assumes arm arrives while idle and tx_end follows it.
module dl_rsp_rx
    import dl_pkg::*;
#(
    parameter int CMD_W     = 8,
    parameter int MAX_WORDS = 62,
    parameter int DEAD_W    = 8,
    parameter int NW_W      = 6,
    parameter int AW        = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [NW_W-1:0]   nwords,
    input  logic [DEAD_W-1:0] dead,
    input  logic              tx_end,
    input  logic              bit_end,
    input  logic              bit_mid,
    input  logic              line_in,
    output logic              busy,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              commit,
    output logic              commit_ok,
    output logic [NW_W-1:0]   n_words,
    output logic              done,
    output logic              perr,
    output logic              crcerr,
    output logic [WORD_W-1:0] ev,
    output logic [WORD_W-1:0] board,
    output logic [WORD_W-1:0] status
);
    localparam int XW   = $clog2(MAX_WORDS + 4);
    localparam int BW   = $clog2(WORD_W);
    localparam int ECHO = CMD_W + 1;

    rx_state_t         st;
    logic [DEAD_W-1:0] dcnt;
    logic [BW-1:0]     bcnt;
    logic [XW-1:0]     widx;
    logic [XW-1:0]     last_idx;
    logic              echo;
    logic              par_bad;
    logic [WORD_W-1:0] sh;
    logic [WORD_W-1:0] sh_next;
    logic [15:0]       crc;
    logic [NW_W-1:0]   nlat;
    logic              word_end;

    // Word boundary detection and buffer write/commit strobes.
    always_comb begin
        sh_next   = {sh[WORD_W-2:0], line_in};
        last_idx  = XW'(nlat) + XW'(3);
        word_end  = (st == RX_RECV) && bit_mid && !echo && (bcnt == BW'(WORD_W - 1));
        wr_en     = word_end && (widx >= XW'(3)) && (widx < last_idx);
        wr_addr   = AW'(widx - XW'(3));
        wr_data   = sh_next;
        commit    = word_end && (widx == last_idx);
        commit_ok = !par_bad && (sh_next == crc);
        n_words   = nlat;
        busy      = (st != RX_IDLE);
    end

    // Receive state machine: arm, dead time, hunt, field collection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= RX_IDLE;
            dcnt    <= '0;
            bcnt    <= '0;
            widx    <= '0;
            echo    <= 1'b0;
            par_bad <= 1'b0;
            sh      <= '0;
            crc     <= CRC_INIT;
            nlat    <= '0;
            done    <= 1'b0;
            perr    <= 1'b0;
            crcerr  <= 1'b0;
            ev      <= '0;
            board   <= '0;
            status  <= '0;
        end else begin
            done <= 1'b0;
            unique case (st)
                RX_IDLE: begin
                    if (arm) begin
                        nlat   <= (nwords > NW_W'(MAX_WORDS)) ? NW_W'(MAX_WORDS) : nwords;
                        dcnt   <= dead;
                        perr   <= 1'b0;
                        crcerr <= 1'b0;
                        st     <= RX_ARM;
                    end
                end
                RX_ARM: begin
                    if (tx_end) begin
                        if (dcnt == '0) begin
                            st <= RX_HUNT;
                        end else begin
                            dcnt <= dcnt - 1'b1;
                            st   <= RX_DEAD;
                        end
                    end
                end
                RX_DEAD: begin
                    if (bit_end) begin
                        if (dcnt == '0) st <= RX_HUNT;
                        else            dcnt <= dcnt - 1'b1;
                    end
                end
                RX_HUNT: begin
                    if (bit_mid && line_in) begin
                        st      <= RX_RECV;
                        echo    <= 1'b1;
                        bcnt    <= '0;
                        widx    <= '0;
                        crc     <= CRC_INIT;
                        par_bad <= 1'b0;
                    end
                end
                RX_RECV: begin
                    if (bit_mid) begin
                        sh <= sh_next;
                        if (echo) begin
                            if (bcnt == BW'(ECHO - 1)) begin
                                par_bad <= ^sh_next[ECHO-1:0];
                                echo    <= 1'b0;
                                bcnt    <= '0;
                            end else begin
                                bcnt <= bcnt + 1'b1;
                            end
                        end else begin
                            if (widx != last_idx) crc <= crc16_bit(crc, line_in);
                            if (bcnt == BW'(WORD_W - 1)) begin
                                bcnt <= '0;
                                widx <= widx + 1'b1;
                                if (widx == XW'(0)) ev     <= sh_next;
                                if (widx == XW'(1)) board  <= sh_next;
                                if (widx == XW'(2)) status <= sh_next;
                                if (widx == last_idx) begin
                                    done   <= 1'b1;
                                    perr   <= par_bad;
                                    crcerr <= (sh_next != crc);
                                    st     <= RX_IDLE;
                                end
                            end else begin
                                bcnt <= bcnt + 1'b1;
                            end
                        end
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dl_word_buf.sv
// Holding buffer for reply data words. Words are written during the frame
// and become readable only after a successful commit; a failed commit leaves
// nothing readable. Assumes clear precedes each frame and the buffer is drained.
module dl_word_buf
    import dl_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = 6,
    parameter int NW_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              commit,
    input  logic              commit_ok,
    input  logic [NW_W-1:0]   commit_cnt,
    input  logic              rd_ready,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic              drained
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic [NW_W-1:0]   avail;
    logic [NW_W-1:0]   rd;

    // Storage write port.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Readable window: set by commit, consumed by the read handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            avail <= '0;
            rd    <= '0;
        end else if (clear) begin
            avail <= '0;
            rd    <= '0;
        end else begin
            if (commit) avail <= commit_ok ? commit_cnt : '0;
            if (rd_valid && rd_ready) rd <= rd + 1'b1;
        end
    end

    assign rd_valid = (rd < avail);
    assign rd_data  = mem[AW'(rd)];
    assign drained  = (rd == avail);
endmodule

// File: rtl/daq_link_engine.sv
// Controller end of the serial acquisition link. Sends a command frame,
// turns the line around after a dead time, receives and checks the reply,
// and releases checked data words. Assumes line_in reflects the shared data
// line while line_oe is low.
module daq_link_engine
    import dl_pkg::*;
#(
    parameter int CMD_W     = 8,
    parameter int DIV       = 4,
    parameter int MAX_WORDS = 62,
    parameter int DEAD_W    = 8,
    parameter int NW_W      = $clog2(MAX_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CMD_W-1:0]  req_cmd,
    input  logic [15:0]       req_event,
    input  logic [NW_W-1:0]   req_nwords,
    input  logic [DEAD_W-1:0] dead_bits,
    output logic              lclk_out,
    output logic              line_out,
    output logic              line_oe,
    input  logic              line_in,
    output logic              cstop,
    output logic              done,
    output logic              parity_error,
    output logic              crc_error,
    output logic [15:0]       rsp_event,
    output logic [15:0]       rsp_board,
    output logic [15:0]       rsp_status,
    output logic              word_valid,
    input  logic              word_ready,
    output logic [15:0]       word_data
);
    localparam int AW    = $clog2(MAX_WORDS);
    localparam int DEPTH = 1 << AW;

    logic              bit_end, bit_mid;
    logic              tx_end, tx_busy, rx_busy, drained;
    logic              accept;
    logic              wr_en, commit, commit_ok;
    logic [AW-1:0]     wr_addr;
    logic [WORD_W-1:0] wr_data;
    logic [NW_W-1:0]   n_words;

    // Request handshake: idle in both directions and buffer emptied.
    always_comb begin
        req_ready = !tx_busy && !rx_busy && drained;
        accept    = req_valid && req_ready;
    end

    dl_bit_timer #(.DIV(DIV)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .lclk    (lclk_out),
        .bit_end (bit_end),
        .bit_mid (bit_mid)
    );

    dl_cmd_tx #(.CMD_W(CMD_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .cmd      (req_cmd),
        .evnum    (req_event),
        .bit_end  (bit_end),
        .bit_mid  (bit_mid),
        .line_out (line_out),
        .line_oe  (line_oe),
        .cstop    (cstop),
        .tx_end   (tx_end),
        .busy     (tx_busy)
    );

    dl_rsp_rx #(
        .CMD_W     (CMD_W),
        .MAX_WORDS (MAX_WORDS),
        .DEAD_W    (DEAD_W),
        .NW_W      (NW_W),
        .AW        (AW)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (accept),
        .nwords    (req_nwords),
        .dead      (dead_bits),
        .tx_end    (tx_end),
        .bit_end   (bit_end),
        .bit_mid   (bit_mid),
        .line_in   (line_in),
        .busy      (rx_busy),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .commit    (commit),
        .commit_ok (commit_ok),
        .n_words   (n_words),
        .done      (done),
        .perr      (parity_error),
        .crcerr    (crc_error),
        .ev        (rsp_event),
        .board     (rsp_board),
        .status    (rsp_status)
    );

    dl_word_buf #(
        .DEPTH (DEPTH),
        .AW    (AW),
        .NW_W  (NW_W)
    ) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .commit     (commit),
        .commit_ok  (commit_ok),
        .commit_cnt (n_words),
        .rd_ready   (word_ready),
        .rd_valid   (word_valid),
        .rd_data    (word_data),
        .drained    (drained)
    );
endmodule

// File: rtl/daq_link_engine_chk.sv
// Temporal checks on the link engine ports, attached by bind.
module daq_link_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        lclk_out,
    input logic        line_out,
    input logic        line_oe,
    input logic        cstop,
    input logic        done,
    input logic        parity_error,
    input logic        crc_error,
    input logic        word_valid,
    input logic        word_ready,
    input logic [15:0] word_data
);
    // R1: an undriven line carries no level.
    p_quiet_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !line_oe |-> !line_out);

    // R3: the strobe only appears with the start level under a high link clock.
    p_cstop_at_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cstop |-> (line_oe && line_out && lclk_out));

    // R3: the strobe lasts one cycle.
    p_cstop_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cstop |=> !cstop);

    // R8: done is a single-cycle pulse.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: a failed frame releases no word.
    p_fail_no_words_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (parity_error || crc_error)) |-> !word_valid);

    // R9: a stalled word stays put.
    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !word_ready) |=> (word_valid && $stable(word_data)));

    // R11: no request is taken while the line is being driven.
    p_ready_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !line_oe);
endmodule

bind daq_link_engine daq_link_engine_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (req_ready),
    .lclk_out     (lclk_out),
    .line_out     (line_out),
    .line_oe      (line_oe),
    .cstop        (cstop),
    .done         (done),
    .parity_error (parity_error),
    .crc_error    (crc_error),
    .word_valid   (word_valid),
    .word_ready   (word_ready),
    .word_data    (word_data)
);

// File: tb/test_daq_link_engine.sv
module test_daq_link_engine;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 180000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_cmd = '0;
    logic [15:0] req_event = '0;
    logic [5:0]  req_nwords = '0;
    logic [7:0]  dead_bits = '0;
    logic        lclk_out, line_out, line_oe;
    logic        line_in = 1'b0;
    logic        cstop, done, parity_error, crc_error;
    logic [15:0] rsp_event, rsp_board, rsp_status;
    logic        word_valid;
    logic        word_ready = 1'b0;
    logic [15:0] word_data;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int cs_cnt = 0;
    int dn_cnt = 0;
    logic       cap_valid;
    logic [15:0] rw [0:70];
    logic        rb [0:1200];

    always #(CLK_PERIOD / 2) clk = ~clk;

    daq_link_engine i_daq_link_engine (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_event(req_event), .req_nwords(req_nwords),
        .dead_bits(dead_bits), .lclk_out(lclk_out), .line_out(line_out),
        .line_oe(line_oe), .line_in(line_in), .cstop(cstop), .done(done),
        .parity_error(parity_error), .crc_error(crc_error), .rsp_event(rsp_event),
        .rsp_board(rsp_board), .rsp_status(rsp_status), .word_valid(word_valid),
        .word_ready(word_ready), .word_data(word_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Strobe and done monitors, sampled away from the active edge.
    always @(negedge clk) begin
        if (cstop) cs_cnt++;
        if (done) begin
            dn_cnt++;
            cap_valid = word_valid;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG_LIMIT) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WDOG_LIMIT);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [15:0] crc_of(input int nw);
        logic [15:0] c = 16'hFFFF;
        for (int w = 0; w < nw; w++) begin
            for (int b = 15; b >= 0; b--) begin
                logic fb = c[15] ^ rw[w][b];
                c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
            end
        end
        return c;
    endfunction

    task automatic frame(input logic [7:0] cmd, input logic [15:0] ev, input logic [5:0] nreq,
                         input logic [7:0] dead, input logic [15:0] board, input logic [15:0] status,
                         input int gap, input bit garb, input bit bad_par, input bit bad_crc,
                         input bit stall);
        int n = (nreq > 6'd62) ? 62 : int'(nreq);
        int nb = 0;
        int expn;
        logic db [0:25];
        logic [7:0] got_cmd;
        logic [15:0] got_ev;
        logic [15:0] crc;

        @(negedge clk);
        check("R11 ready before request", {31'd0, req_ready}, 32'd1);
        cs_cnt = 0;
        dn_cnt = 0;
        req_cmd = cmd; req_event = ev; req_nwords = nreq; dead_bits = dead;
        req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
        check("R11 ready after accept", {31'd0, req_ready}, 32'd0);

        // Capture the downstream frame at link clock rises.
        do begin
            @(posedge lclk_out); #1;
        end while (!(line_oe && line_out));
        check("R3 cstop at start bit", {31'd0, cstop}, 32'd1);
        db[0] = line_out;
        for (int i = 1; i < 26; i++) begin
            @(posedge lclk_out); #1;
            check("R1 line driven in frame", {31'd0, line_oe}, 32'd1);
            db[i] = line_out;
        end
        for (int i = 0; i < 8; i++) got_cmd[7-i] = db[1+i];
        for (int i = 0; i < 16; i++) got_ev[15-i] = db[10+i];
        check("R1 command bits", {24'd0, got_cmd}, {24'd0, cmd});
        check("R1 parity bit", {31'd0, db[9]}, {31'd0, ^cmd});
        check("R1 event bits", {16'd0, got_ev}, {16'd0, ev});
        @(negedge lclk_out); #1;
        check("R4 line released", {31'd0, line_oe}, 32'd0);

        // Build the reply.
        rw[0] = ev; rw[1] = board; rw[2] = status;
        for (int j = 0; j < n; j++)
            rw[3+j] = 16'(ev + 16'h0F1D * 16'(j + 1)) ^ {cmd, 8'(j)};
        crc = crc_of(n + 3) ^ (bad_crc ? 16'h0001 : 16'h0000);
        rw[n+3] = crc;
        rb[nb++] = 1'b1;
        for (int i = 7; i >= 0; i--) rb[nb++] = cmd[i];
        rb[nb++] = (^cmd) ^ bad_par;
        for (int w = 0; w < n + 4; w++)
            for (int b = 15; b >= 0; b--) rb[nb++] = rw[w][b];

        // Dead window (optionally a high level) and idle gap, then the reply.
        for (int k = 0; k < int'(dead) + gap; k++) begin
            line_in = garb && (k < int'(dead));
            @(negedge lclk_out); #1;
        end
        for (int i = 0; i < nb; i++) begin
            line_in = rb[i];
            @(negedge lclk_out); #1;
        end
        line_in = 1'b0;
        @(negedge clk);

        expn = (!bad_par && !bad_crc) ? n : 0;
        check("R3 one cstop per frame", cs_cnt, 1);
        check("R8 one done pulse", dn_cnt, 1);
        check("R6 parity flag", {31'd0, parity_error}, {31'd0, bad_par});
        check("R7 crc flag", {31'd0, crc_error}, {31'd0, bad_crc});
        check("R8 event field", {16'd0, rsp_event}, {16'd0, ev});
        check("R8 board field", {16'd0, rsp_board}, {16'd0, board});
        check("R8 status field", {16'd0, rsp_status}, {16'd0, status});
        check("R9 valid at done", {31'd0, cap_valid}, {31'd0, expn > 0});
        if (expn > 0) check("R11 ready held while unread", {31'd0, req_ready}, 32'd0);

        for (int j = 0; j < expn; j++) begin
            @(negedge clk);
            if (stall && j == 1) begin
                for (int s = 0; s < 3; s++) begin
                    check("R9 stalled valid", {31'd0, word_valid}, 32'd1);
                    check("R9 stalled data", {16'd0, word_data}, {16'd0, rw[3+j]});
                    @(negedge clk);
                end
            end
            check("R9 word valid", {31'd0, word_valid}, 32'd1);
            check("R9 word data in order", {16'd0, word_data}, {16'd0, rw[3+j]});
            word_ready = 1'b1;
            @(negedge clk);
            word_ready = 1'b0;
        end
        @(negedge clk);
        check("R10 no extra word", {31'd0, word_valid}, 32'd0);
        check("R11 ready after drain", {31'd0, req_ready}, 32'd1);
        check("R8 parity flag held", {31'd0, parity_error}, {31'd0, bad_par});
    endtask

    initial begin
        int highs = 0;
        int rises = 0;
        logic prev;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset ready", {31'd0, req_ready}, 32'd1);
        check("R11 reset done", {31'd0, done}, 32'd0);
        check("R11 reset flags", {30'd0, parity_error, crc_error}, 32'd0);
        check("R11 reset valid", {31'd0, word_valid}, 32'd0);
        check("R1 reset line", {30'd0, line_oe, line_out}, 32'd0);

        // R2: link clock duty and period over 16 cycles.
        prev = lclk_out;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (lclk_out) highs++;
            if (lclk_out && !prev) rises++;
            prev = lclk_out;
        end
        check("R2 lclk high cycles", highs, 8);
        check("R2 lclk rises", rises, 4);

        // R5 R10: short replies with varied dead time and idle gaps.
        for (int k = 0; k < 8; k++)
            frame(8'(8'h35 * k + 1), 16'(16'h1234 + k * 16'h0111), 6'(k), 8'(k % 4),
                  16'(16'hB000 + k), 16'(16'h5A00 ^ k), k % 3, 1'b0, 1'b0, 1'b0, k >= 2);
        // R10: long replies and the clamped request.
        frame(8'hC3, 16'hFFFF, 6'd61, 8'd5, 16'h0001, 16'h8000, 0, 1'b0, 1'b0, 1'b0, 1'b1);
        frame(8'h00, 16'h0000, 6'd62, 8'd1, 16'hFFFF, 16'h0000, 1, 1'b0, 1'b0, 1'b0, 1'b0);
        frame(8'hFF, 16'hA5A5, 6'd63, 8'd2, 16'h7E7E, 16'h0F0F, 0, 1'b0, 1'b0, 1'b0, 1'b1);
        // R4: high level held through the dead window must be ignored.
        frame(8'h5C, 16'h4321, 6'd3, 8'd3, 16'h2222, 16'h3333, 0, 1'b1, 1'b0, 1'b0, 1'b0);
        frame(8'h81, 16'h0042, 6'd2, 8'd6, 16'h4444, 16'h5555, 2, 1'b1, 1'b0, 1'b0, 1'b0);
        // R6 R7: corrupted checks drop the data words.
        frame(8'h12, 16'h1111, 6'd4, 8'd2, 16'h0A0A, 16'h0B0B, 0, 1'b0, 1'b1, 1'b0, 1'b0);
        frame(8'h34, 16'h2222, 6'd4, 8'd2, 16'h0C0C, 16'h0D0D, 1, 1'b0, 1'b0, 1'b1, 1'b0);
        frame(8'h56, 16'h3333, 6'd4, 8'd0, 16'h0E0E, 16'h0F0F, 0, 1'b0, 1'b1, 1'b1, 1'b0);
        // R1 R6: sweep across command values with empty replies.
        for (int k = 0; k < 64; k++)
            frame(8'(4 * k + (k % 4)), 16'(k * 16'h0403), 6'd0, 8'(k % 3),
                  16'(k), 16'(~k), 0, 1'b0, 1'b0, 1'b0, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule